// File: doc/BRIEF.md
# Key-Gated Register Write Lock

This block guards a small bank of memory-mapped configuration words against stray writes. It sits on a simple register bus: word address, write data, a write strobe and a combinational read-data return. The protected words can be read at any time. A write to one of them only takes effect once software has unlocked the bank by storing two exact 32-bit key values into two dedicated key registers.

Each key register keeps its own "correct key seen" flag. The two flags may be set in either order, and the bank counts as unlocked while both are set. Storing any other value into either key register clears both flags at once, which locks the bank again. Software is expected to relock the bank this way when it has finished its configuration writes. Words marked read-only in a per-word writable mask ignore writes even while the bank is unlocked. A write to a protected word while the bank is locked is dropped without any error indication.

The address map uses word addresses. The protected words sit at addresses 0 to NUM_REGS-1. The first key register is at NUM_REGS and the second key register is at NUM_REGS+1. Every higher address is unmapped.

Top module: `cfg_write_lock`

## Requirements
- R1: After reset the bank is locked and protected word i holds RST_BASE + i*RST_STEP (defaults 0x5A000000 and 0x00010203).
- R2: Reads are never blocked. When addr_i selects protected word i, rdata_o equals that word in the same cycle, whether the bank is locked or unlocked.
- R3: The bank unlocks once 0x83E70B13 has been written to the first key register (address NUM_REGS) and 0x95A4F1E0 has been written to the second key register (address NUM_REGS+1), in either order. A protected write is accepted from the cycle after the second correct key write onward.
- R4: A write of any other value to either key register clears both key flags. The bank is locked from the next cycle, and all unlock progress is lost.
- R5: While the bank is locked, a write to a protected word leaves the word unchanged.
- R6: A word whose bit in WR_MASK is 0 (default mask 8'b1011_0110, so words 0, 3 and 6 are read-only) never changes, even while the bank is unlocked.
- R7: Both key registers read back as zero.
- R8: Addresses NUM_REGS+2 and above read as zero, and writes to them do not change the lock state or any key flag.
- R9: While the bank is unlocked, a write to a writable protected word stores all 32 bits of the write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| cfg_o | output | NUM_REGS*32 | All protected words, word i at bits [32*i +: 32] |

## Verification
After every step the bench sweeps all sixteen addresses and compares each one with a model derived from the requirements.

Write bursts go to every protected word with several data patterns, under these lock histories:
- **No key, or only one correct key:** shows that the bank really stays closed until both keys are in.
- **Both keys in each order:** shows that the order of the key writes does not matter.
- **A correct key, then a wrong one, then the other correct key:** shows that a wrong value clears earlier progress rather than only blocking the key it was written to.
- **Unmapped-address writes between the unlock and the bank writes:** show that those writes leave the lock state alone.

Comparing the writable and read-only words after each unlocked burst shows whether the mask is applied per word.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/cwl_decode.sv
module cwl_decode #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned NUM_REGS = 8
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_REGS-1:0] bank_we_o,
  output logic              key0_we_o,
  output logic              key1_we_o
);
  localparam logic [ADDR_W-1:0] KEY0_ADDR = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] KEY1_ADDR = ADDR_W'(NUM_REGS + 1);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign bank_we_o[i] = we_i && (addr_i == ADDR_W'(i));
  end

  assign key0_we_o = we_i && (addr_i == KEY0_ADDR);
  assign key1_we_o = we_i && (addr_i == KEY1_ADDR);
endmodule

// File: rtl/cwl_key_lock.sv
module cwl_key_lock
  import cwl_pkg::*;
#(
  parameter word_t KEY0 = 32'h83E7_0B13,
  parameter word_t KEY1 = 32'h95A4_F1E0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key0_we_i,
  input  logic       key1_we_i,
  input  word_t      wdata_i,
  output logic [1:0] flags_o,
  output logic       unlocked_o
);
  logic [1:0] flags_q, flags_d;
  logic       bad_key;

  // a miss on either key register drops all progress
  assign bad_key = (key0_we_i && wdata_i != KEY0) || (key1_we_i && wdata_i != KEY1);

  always_comb begin
    flags_d = flags_q;
    if (bad_key) begin
      flags_d = 2'b00;
    end else begin
      if (key0_we_i) flags_d[0] = 1'b1;
      if (key1_we_i) flags_d[1] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= 2'b00;
    else         flags_q <= flags_d;
  end

  assign flags_o    = flags_q;
  assign unlocked_o = &flags_q;
endmodule

// File: rtl/cwl_reg_bank.sv
module cwl_reg_bank
  import cwl_pkg::*;
#(
  parameter int unsigned          NUM_REGS = 8,
  parameter logic [NUM_REGS-1:0]  WR_MASK  = 8'b1011_0110,
  parameter word_t                RST_BASE = 32'h5A00_0000,
  parameter word_t                RST_STEP = 32'h0001_0203
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                unlocked_i,
  input  logic [NUM_REGS-1:0] sel_we_i,
  input  word_t               wdata_i,
  output word_t               regs_o [NUM_REGS]
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam word_t RST_VAL = RST_BASE + word_t'(i) * RST_STEP;
    if (WR_MASK[i]) begin : g_rw
      word_t q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       q <= RST_VAL;
        else if (sel_we_i[i] && unlocked_i) q <= wdata_i;
      end
      assign regs_o[i] = q;
    end else begin : g_ro
      assign regs_o[i] = RST_VAL;
    end
  end
endmodule

// File: rtl/cfg_write_lock.sv
module cfg_write_lock
  import cwl_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 4,
  parameter int unsigned          NUM_REGS = 8,
  parameter logic [NUM_REGS-1:0]  WR_MASK  = 8'b1011_0110,
  parameter word_t                RST_BASE = 32'h5A00_0000,
  parameter word_t                RST_STEP = 32'h0001_0203,
  parameter word_t                KEY0     = 32'h83E7_0B13,
  parameter word_t                KEY1     = 32'h95A4_F1E0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [31:0]                wdata_i,
  output logic [31:0]                rdata_o,
  output logic [NUM_REGS*WORD_W-1:0] cfg_o
);
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0] bank_we;
  logic                key0_we, key1_we, unlocked;
  logic [1:0]          key_flags;
  word_t               regs_q [NUM_REGS];

  cwl_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
    .we_i(we_i), .addr_i(addr_i), .bank_we_o(bank_we),
    .key0_we_o(key0_we), .key1_we_o(key1_we)
  );

  cwl_key_lock #(.KEY0(KEY0), .KEY1(KEY1)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .key0_we_i(key0_we), .key1_we_i(key1_we),
    .wdata_i(wdata_i), .flags_o(key_flags), .unlocked_o(unlocked)
  );

  cwl_reg_bank #(
    .NUM_REGS(NUM_REGS), .WR_MASK(WR_MASK), .RST_BASE(RST_BASE), .RST_STEP(RST_STEP)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .unlocked_i(unlocked), .sel_we_i(bank_we),
    .wdata_i(wdata_i), .regs_o(regs_q)
  );

  // keys and unmapped space read zero
  always_comb begin
    rdata_o = '0;
    if (addr_i < ADDR_W'(NUM_REGS)) rdata_o = regs_q[IDX_W'(addr_i)];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_out
    assign cfg_o[i*WORD_W +: WORD_W] = regs_q[i];
  end
endmodule

// File: rtl/cwl_chk.sv
module cwl_chk
  import cwl_pkg::*;
#(
  parameter int unsigned         ADDR_W   = 4,
  parameter int unsigned         NUM_REGS = 8,
  parameter logic [NUM_REGS-1:0] WR_MASK  = 8'b1011_0110,
  parameter word_t               KEY0     = 32'h83E7_0B13,
  parameter word_t               KEY1     = 32'h95A4_F1E0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              unlocked,
  input logic [1:0]        key_flags,
  input word_t             regs_q [NUM_REGS]
);
  localparam logic [ADDR_W-1:0] K0A = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] K1A = ADDR_W'(NUM_REGS + 1);

  assert_unlock_k1_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == K1A && wdata_i == KEY1 && key_flags[0]) |=> unlocked);
  assert_unlock_k0_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == K0A && wdata_i == KEY0 && key_flags[1]) |=> unlocked);

  assert_bad_key_relock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ((addr_i == K0A && wdata_i != KEY0) || (addr_i == K1A && wdata_i != KEY1)))
    |=> (key_flags == 2'b00));

  assert_key_read_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == K0A || addr_i == K1A) |-> (rdata_o == 32'h0));

  assert_unmapped_keeps_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i > K1A) |=> $stable(key_flags));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    assert_read_always_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == ADDR_W'(i)) |-> (rdata_o == regs_q[i]));
    assert_locked_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(i) && !unlocked) |=> $stable(regs_q[i]));
    if (!WR_MASK[i]) begin : g_ro
      assert_ro_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> $stable(regs_q[i]));
    end else begin : g_rw
      assert_open_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == ADDR_W'(i) && unlocked) |=> (regs_q[i] == $past(wdata_i)));
    end
  end
endmodule

bind cfg_write_lock cwl_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .WR_MASK(WR_MASK), .KEY0(KEY0), .KEY1(KEY1)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .unlocked(unlocked), .key_flags(key_flags), .regs_q(regs_q)
);

// File: tb/cfg_write_lock_bench.sv
module cfg_write_lock_bench;
  localparam int unsigned NR = 8;
  localparam int unsigned AW = 4;
  localparam logic [7:0]  MASK = 8'b1011_0110;
  localparam logic [31:0] K0 = 32'h83E7_0B13;
  localparam logic [31:0] K1 = 32'h95A4_F1E0;

  logic clk_i = 1'b0, rst_ni = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [NR*32-1:0] cfg_o;

  int checks = 0, errors = 0;
  logic [31:0] exp_mem [NR];
  logic f0, f1;

  always #2.5 clk_i = ~clk_i;

  cfg_write_lock u_cfg_write_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cfg_o(cfg_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // model follows the requirements: lock state before the write gates it
  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    logic open;
    open = f0 && f1;
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
    if (a == AW'(NR)) begin
      if (d == K0) f0 = 1'b1; else begin f0 = 1'b0; f1 = 1'b0; end
    end else if (a == AW'(NR + 1)) begin
      if (d == K1) f1 = 1'b1; else begin f0 = 1'b0; f1 = 1'b0; end
    end else if (a < AW'(NR)) begin
      if (open && MASK[a]) exp_mem[a] = d;
    end
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk_i);
      addr_i = AW'(a);
      #1;
      chk(req, rdata_o, (a < NR) ? exp_mem[a] : 32'h0);
      if (a < NR) chk(req, cfg_o[a*32 +: 32], exp_mem[a]);
    end
  endtask

  task automatic burst(logic [31:0] seed);
    for (int i = 0; i < NR; i++) wr(AW'(i), seed ^ (32'h1111_1111 * i));
  endtask

  initial begin
    for (int i = 0; i < NR; i++) exp_mem[i] = 32'h5A00_0000 + i * 32'h0001_0203;
    f0 = 1'b0; f1 = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    sweep("R1 reset values, R7 key zero, R8 unmapped zero");

    burst(32'hDEAD_BEEF);
    sweep("R5 locked writes dropped");

    wr(AW'(NR), K0);
    burst(32'h0F0F_0F0F);
    sweep("R3 one key only stays locked");

    wr(AW'(NR + 1), K1);
    burst(32'hCAFE_0001);
    sweep("R3 key0 then key1 unlocks, R6 read-only kept, R9 full word");

    wr(AW'(14), 32'h1234_5678);
    wr(AW'(10), K0);
    burst(32'hFFFF_FFFF);
    sweep("R8 unmapped writes keep unlock, R2 read while unlocked");

    wr(AW'(NR), 32'h0);
    burst(32'h0000_0000);
    sweep("R4 wrong key0 relocks");

    wr(AW'(NR + 1), K1);
    wr(AW'(NR), K0);
    burst(32'hA5A5_5A5A);
    sweep("R3 key1 then key0 unlocks");

    wr(AW'(NR + 1), K1 ^ 32'h1);
    burst(32'h1357_9BDF);
    sweep("R4 wrong key1 relocks");

    wr(AW'(NR), K0);
    wr(AW'(NR + 1), 32'h83E7_0B13);
    wr(AW'(NR + 1), K1);
    burst(32'h2468_ACE0);
    sweep("R4 progress cleared by wrong key");

    wr(AW'(NR), K0);
    burst(32'h7777_8888);
    sweep("R3 R9 reopen after full key pair");

    wr(AW'(NR + 1), 32'h0);
    sweep("R2 read while locked after relock");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule